// File: doc/BRIEF.md
# Processor Exception State Unit

This block keeps the exception control state of a small 32-bit processor core. It tracks two nesting levels: an exception level for ordinary traps and an error level for reset, soft reset and non-maskable interrupt. It also holds the two return addresses that belong to those levels, a status word and a cause word. The pipeline reports a trap with a one-cycle strobe. It supplies the cause code, the address of the faulting instruction, and a flag that says the instruction sits in a branch delay slot. The block then records what the handler needs and presents the handler's entry address.

A return strobe unwinds one level. The error level unwinds first, and then the exception level. The resume address output always points at the return address of the innermost active level. Two further outputs are derived from the level state and the status bits: the global interrupt-enable condition and the user/kernel mode. Software reaches all of this through a simple register port with a combinational read.

The level state is a four-state machine. The states are LV_NORMAL (no level set), LV_EXC (exception level only), LV_ERR (error level only) and LV_BOTH (both set). The state after reset is LV_ERR. The transitions are:
- Error strobe: goes to LV_ERR from LV_NORMAL or LV_ERR, and to LV_BOTH from LV_EXC or LV_BOTH.
- Trap strobe: goes to LV_EXC from LV_NORMAL or LV_EXC, and to LV_BOTH from LV_ERR or LV_BOTH.
- Return strobe: goes to LV_NORMAL from LV_EXC or LV_ERR, and from LV_BOTH to LV_EXC. In LV_NORMAL it has no effect.

Top module: `trap_ctl`

## Requirements
- R1: After reset the error level is 1, the exception level is 0, the bootstrap flag is 1, interrupt enable, user bit and priority are 0, both return PCs are 0 and the vector base is 0x80000000. The status word therefore reads 0x84.
- R2: A trap strobe taken while the exception level is 0 sets that level, loads the return PC and updates the branch-delay bit. When the level is already 1, the return PC and the branch-delay bit keep their values. Every accepted trap loads the 5-bit cause code.
- R3: A trap with the delay-slot flag set stores the faulting PC minus 4 and sets the branch-delay bit (cause bit 31). Without the flag the block stores the faulting PC itself and clears the branch-delay bit.
- R4: An error strobe sets the error level and loads the faulting PC into the error return PC. The normal return PC, the cause word and the exception level are left untouched.
- R5: A return strobe clears the error level if it is 1. Otherwise it clears the exception level. The resume output shows the error return PC while the error level is 1 and the normal return PC otherwise.
- R6: Interrupt enable is high only when status bit IE is 1, both levels are 0 and the debug-mode input is 0.
- R7: User mode is high only when the user bit is 1 and both levels are 0.
- R8: While the error strobe is high, the vector output is 0xBFC00000. Otherwise it is 0xBFC00380 when the bootstrap flag is 1, and the vector base plus 0x180 when the flag is 0.
- R9: When strobes coincide, the error strobe wins over the trap strobe, which wins over the return strobe. A losing strobe has no effect at all.
- R10: The register addresses are 0 status, 1 cause, 2 return PC, 3 error return PC and 4 vector base. Unmapped addresses read 0. The status layout is IE bit 0, exception level bit 1, error level bit 2, user bit 3, priority bits 6:4 and bootstrap bit 7. Software writes change only IE, user, priority and bootstrap. Writes to the level bits and to the cause word have no effect. Both return PCs and the base are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exc_take | input | 1 | General trap strobe |
| exc_code | input | 5 | Cause code of the trap |
| exc_pc | input | 32 | Faulting instruction address |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| err_take | input | 1 | Error-class strobe (reset, soft reset, NMI) |
| eret | input | 1 | Return-from-exception strobe |
| debug_mode | input | 1 | Processor is in debug mode |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| resume_pc | output | 32 | Address the return strobe resumes at |
| vector_pc | output | 32 | Exception entry address |
| irq_enable | output | 1 | Global interrupt-enable condition |
| user_mode | output | 1 | 1 = user mode, 0 = kernel mode |

## Verification
Each strobe or write updates a register on the next rising edge. From that edge on, resume_pc, irq_enable, user_mode and reg_rdata show the new state with no further delay. vector_pc and the debug-mode gating of irq_enable follow their inputs combinationally in the same cycle. The driver changes inputs on falling edges and queues the expected values. The monitor pops the queue 5 ns after the next rising edge, which is the first instant at which every result is due. Strobes are dropped one cycle before a read is queued, so that the read reflects the state after exactly one update.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        LV_NORMAL = 2'd0,
        LV_EXC    = 2'd1,
        LV_ERR    = 2'd2,
        LV_BOTH   = 2'd3
    } level_e;

    localparam int ADDR_W     = 3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RETPC  = 3'd2;
    localparam logic [ADDR_W-1:0] A_ERRPC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_VBASE  = 3'd4;

    localparam int ST_IE   = 0;
    localparam int ST_EXL  = 1;
    localparam int ST_ERL  = 2;
    localparam int ST_UM   = 3;
    localparam int ST_IPL  = 4;
    localparam int ST_BEV  = 7;
endpackage

// File: rtl/trap_level_fsm.sv
module trap_level_fsm
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_take,
    input  logic err_take,
    input  logic eret,
    output logic exl,
    output logic erl,
    output logic acc_exc,
    output logic acc_err,
    output logic cap_ret
);
    level_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_ERR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_NORMAL: begin
                if (err_take)      state_d = LV_ERR;
                else if (exc_take) state_d = LV_EXC;
            end
            LV_EXC: begin
                if (err_take)      state_d = LV_BOTH;
                else if (exc_take) state_d = LV_EXC;
                else if (eret)     state_d = LV_NORMAL;
            end
            LV_ERR: begin
                if (err_take)      state_d = LV_ERR;
                else if (exc_take) state_d = LV_BOTH;
                else if (eret)     state_d = LV_NORMAL;
            end
            LV_BOTH: begin
                if (eret && !err_take && !exc_take) state_d = LV_EXC;
            end
            default: state_d = LV_ERR;
        endcase
    end

    always_comb begin
        exl     = (state_q == LV_EXC) || (state_q == LV_BOTH);
        erl     = (state_q == LV_ERR) || (state_q == LV_BOTH);
        acc_err = err_take;
        acc_exc = exc_take && !err_take;
        cap_ret = acc_exc && !exl;
    end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int CODE_W      = 5,
    parameter int IPL_W       = 3,
    parameter logic [XLEN-1:0] RESET_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_exc,
    input  logic              acc_err,
    input  logic              cap_ret,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_in_delay,
    input  logic              exl,
    input  logic              erl,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic [XLEN-1:0]   ret_pc,
    output logic [XLEN-1:0]   err_pc,
    output logic [XLEN-1:0]   vbase,
    output logic              ie,
    output logic              um,
    output logic              bev
);
    localparam logic [XLEN-1:0] SLOT_BYTES = XLEN'(4);

    logic [IPL_W-1:0]  ipl_q;
    logic [CODE_W-1:0] code_q;
    logic              bd_q;
    logic              wr_status, wr_ret, wr_err, wr_base;

    assign wr_status = reg_wr && (reg_addr == A_STATUS);
    assign wr_ret    = reg_wr && (reg_addr == A_RETPC);
    assign wr_err    = reg_wr && (reg_addr == A_ERRPC);
    assign wr_base   = reg_wr && (reg_addr == A_VBASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie     <= 1'b0;
            um     <= 1'b0;
            bev    <= 1'b1;
            ipl_q  <= '0;
            code_q <= '0;
            bd_q   <= 1'b0;
            ret_pc <= '0;
            err_pc <= '0;
            vbase  <= RESET_BASE;
        end else begin
            if (wr_status) begin
                ie    <= reg_wdata[ST_IE];
                um    <= reg_wdata[ST_UM];
                ipl_q <= reg_wdata[ST_IPL +: IPL_W];
                bev   <= reg_wdata[ST_BEV];
            end
            if (acc_exc) code_q <= exc_code;
            if (cap_ret) begin
                ret_pc <= exc_in_delay ? (exc_pc - SLOT_BYTES) : exc_pc;
                bd_q   <= exc_in_delay;
            end else if (wr_ret) begin
                ret_pc <= reg_wdata;
            end
            if (acc_err)     err_pc <= exc_pc;
            else if (wr_err) err_pc <= reg_wdata;
            if (wr_base) vbase <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STATUS: begin
                reg_rdata[ST_IE]              = ie;
                reg_rdata[ST_EXL]             = exl;
                reg_rdata[ST_ERL]             = erl;
                reg_rdata[ST_UM]              = um;
                reg_rdata[ST_IPL +: IPL_W]    = ipl_q;
                reg_rdata[ST_BEV]             = bev;
            end
            A_CAUSE: begin
                reg_rdata[CODE_W-1:0] = code_q;
                reg_rdata[XLEN-1]     = bd_q;
            end
            A_RETPC: reg_rdata = ret_pc;
            A_ERRPC: reg_rdata = err_pc;
            A_VBASE: reg_rdata = vbase;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] BOOT_REGION  = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] GEN_OFFSET   = 32'h0000_0180,
    parameter logic [XLEN-1:0] BOOT_SKIP    = 32'h0000_0200
) (
    input  logic            err_take,
    input  logic            bev,
    input  logic [XLEN-1:0] vbase,
    input  logic [XLEN-1:0] ret_pc,
    input  logic [XLEN-1:0] err_pc,
    input  logic            ie,
    input  logic            um,
    input  logic            exl,
    input  logic            erl,
    input  logic            debug_mode,
    output logic [XLEN-1:0] vector_pc,
    output logic [XLEN-1:0] resume_pc,
    output logic            irq_enable,
    output logic            user_mode
);
    localparam logic [XLEN-1:0] BOOT_GEN = BOOT_REGION + BOOT_SKIP + GEN_OFFSET;

    always_comb begin
        if (err_take)  vector_pc = BOOT_REGION;
        else if (bev)  vector_pc = BOOT_GEN;
        else           vector_pc = vbase + GEN_OFFSET;
        resume_pc  = erl ? err_pc : ret_pc;
        irq_enable = ie && !exl && !erl && !debug_mode;
        user_mode  = um && !exl && !erl;
    end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5,
    parameter int IPL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_take,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_in_delay,
    input  logic              err_take,
    input  logic              eret,
    input  logic              debug_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic [XLEN-1:0]   resume_pc,
    output logic [XLEN-1:0]   vector_pc,
    output logic              irq_enable,
    output logic              user_mode
);
    logic exl, erl, acc_exc, acc_err, cap_ret;
    logic ie, um, bev;
    logic [XLEN-1:0] ret_pc, err_pc, vbase;

    trap_level_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .err_take(err_take),
        .eret(eret), .exl(exl), .erl(erl), .acc_exc(acc_exc),
        .acc_err(acc_err), .cap_ret(cap_ret)
    );

    trap_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .IPL_W(IPL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_exc(acc_exc), .acc_err(acc_err),
        .cap_ret(cap_ret), .exc_code(exc_code), .exc_pc(exc_pc),
        .exc_in_delay(exc_in_delay), .exl(exl), .erl(erl), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ret_pc(ret_pc), .err_pc(err_pc), .vbase(vbase), .ie(ie), .um(um),
        .bev(bev)
    );

    trap_vec #(.XLEN(XLEN)) u_vec (
        .err_take(err_take), .bev(bev), .vbase(vbase), .ret_pc(ret_pc),
        .err_pc(err_pc), .ie(ie), .um(um), .exl(exl), .erl(erl),
        .debug_mode(debug_mode), .vector_pc(vector_pc), .resume_pc(resume_pc),
        .irq_enable(irq_enable), .user_mode(user_mode)
    );

    // R2: nested trap leaves the return PC alone
    assert_ret_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !err_take && exl && !(reg_wr && reg_addr == A_RETPC))
        |=> $stable(ret_pc));

    // R4: error strobe always raises the error level, exception level kept
    assert_err_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_take |=> (erl && $stable(exl)));

    // R5: return unwinds the error level first
    assert_ret_unwind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_take && !err_take && erl) |=> (!erl && $stable(exl)));

    // R6: interrupts never enabled inside a handler or in debug mode
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enable |-> (!exl && !erl && !debug_mode));

    // R7: user mode implies no active level
    assert_user_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> (!exl && !erl));

    // R9: a trap beats a simultaneous return
    assert_trap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && eret && !err_take) |=> exl);
endmodule

// File: tb/test_trap_ctl.sv
module test_trap_ctl;
    import trap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_take = 1'b0, exc_in_delay = 1'b0, err_take = 1'b0;
    logic        eret = 1'b0, debug_mode = 1'b0, reg_wr = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0, reg_wdata = '0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_rdata, resume_pc, vector_pc;
    logic        irq_enable, user_mode;

    always #10 clk = ~clk;  // 50 MHz

    trap_ctl i_trap_ctl (
        .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .err_take(err_take),
        .eret(eret), .debug_mode(debug_mode), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .resume_pc(resume_pc), .vector_pc(vector_pc),
        .irq_enable(irq_enable), .user_mode(user_mode)
    );

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    localparam int S_RESUME = 0, S_VEC = 1, S_IRQ = 2, S_USER = 3, S_RD = 4;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_RESUME: return resume_pc;
            S_VEC:    return vector_pc;
            S_IRQ:    return {31'd0, irq_enable};
            S_USER:   return {31'd0, user_mode};
            default:  return reg_rdata;
        endcase
    endfunction

    // monitor: results are due 5 ns after the edge that follows the push
    always @(posedge clk) begin
        #5;
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_val(string req, int sel, logic [31:0] v);
        sb.push_back('{req, sel, v});
    endtask

    task automatic drive(bit ex, logic [4:0] code, logic [31:0] pc, bit dly,
                         bit er, bit rt, bit wr, logic [2:0] a, logic [31:0] wd);
        @(negedge clk);
        exc_take = ex; exc_code = code; exc_pc = pc; exc_in_delay = dly;
        err_take = er; eret = rt; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    endtask

    task automatic quiet(logic [2:0] a);
        @(negedge clk);
        exc_take = 0; err_take = 0; eret = 0; reg_wr = 0; exc_in_delay = 0;
        reg_addr = a;
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        drive(0, '0, '0, 0, 0, 0, 1, a, d);
    endtask

    task automatic read_chk(string req, logic [2:0] a, logic [31:0] v);
        quiet(a);
        expect_val(req, S_RD, v);
        wait (sb.size() == 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        quiet(A_STATUS);
        expect_val("R1", S_RD, 32'h84);
        expect_val("R1", S_RESUME, 32'h0);
        expect_val("R1", S_IRQ, 0);
        expect_val("R1", S_USER, 0);
        wait (sb.size() == 0);
        read_chk("R1", A_VBASE, 32'h8000_0000);
        read_chk("R1", A_CAUSE, 32'h0);

        // R5 return from the reset error level
        drive(0, '0, '0, 0, 0, 1, 0, A_STATUS, '0);
        read_chk("R5", A_STATUS, 32'h80);

        // R10 write all ones to status: level bits stay clear
        wr_reg(A_STATUS, 32'hFFFF_FFFF);
        read_chk("R10", A_STATUS, 32'hF9);
        quiet(A_STATUS);
        expect_val("R6", S_IRQ, 1);
        expect_val("R7", S_USER, 1);
        expect_val("R8", S_VEC, 32'hBFC0_0380);
        wait (sb.size() == 0);
        // R6 debug mode masks interrupts
        @(negedge clk); debug_mode = 1;
        expect_val("R6", S_IRQ, 0);
        wait (sb.size() == 0);
        @(negedge clk); debug_mode = 0;

        // R8 programmable base when bootstrap flag clear
        wr_reg(A_VBASE, 32'h9D00_0000);
        wr_reg(A_STATUS, 32'h09);
        quiet(A_STATUS);
        expect_val("R8", S_VEC, 32'h9D00_0180);
        wait (sb.size() == 0);

        // R2 first trap
        drive(1, 5'd5, 32'h1000, 0, 0, 0, 0, A_CAUSE, '0);
        quiet(A_CAUSE);
        expect_val("R2", S_RD, 32'h5);
        expect_val("R2", S_RESUME, 32'h1000);
        expect_val("R6", S_IRQ, 0);
        expect_val("R7", S_USER, 0);
        wait (sb.size() == 0);
        read_chk("R2", A_STATUS, 32'h0B);
        // R2 nested trap: return PC and delay bit frozen, code updated
        drive(1, 5'd9, 32'h2000, 1, 0, 0, 0, A_CAUSE, '0);
        read_chk("R2", A_CAUSE, 32'h9);
        read_chk("R2", A_RETPC, 32'h1000);
        // R5 return clears exception level
        drive(0, '0, '0, 0, 0, 1, 0, A_STATUS, '0);
        quiet(A_STATUS);
        expect_val("R5", S_RD, 32'h09);
        expect_val("R5", S_RESUME, 32'h1000);
        expect_val("R6", S_IRQ, 1);
        expect_val("R7", S_USER, 1);
        wait (sb.size() == 0);

        // R3 delay slot trap
        drive(1, 5'd4, 32'h3004, 1, 0, 0, 0, A_CAUSE, '0);
        quiet(A_CAUSE);
        expect_val("R3", S_RD, 32'h8000_0004);
        expect_val("R3", S_RESUME, 32'h3000);
        wait (sb.size() == 0);

        // R4 error strobe while exception level set
        drive(0, '0, 32'h4444, 0, 1, 0, 0, A_RETPC, '0);
        expect_val("R8", S_VEC, 32'hBFC0_0000);
        wait (sb.size() == 0);
        quiet(A_RETPC);
        expect_val("R4", S_RD, 32'h3000);
        expect_val("R4", S_RESUME, 32'h4444);
        wait (sb.size() == 0);
        read_chk("R4", A_STATUS, 32'h0F);
        read_chk("R4", A_CAUSE, 32'h8000_0004);
        // R5 return unwinds error level only
        drive(0, '0, '0, 0, 0, 1, 0, A_STATUS, '0);
        quiet(A_STATUS);
        expect_val("R5", S_RD, 32'h0B);
        expect_val("R5", S_RESUME, 32'h3000);
        wait (sb.size() == 0);
        drive(0, '0, '0, 0, 0, 1, 0, A_STATUS, '0);
        read_chk("R5", A_STATUS, 32'h09);

        // R9 trap and return together: trap wins
        drive(1, 5'd7, 32'h5000, 0, 0, 1, 0, A_STATUS, '0);
        quiet(A_STATUS);
        expect_val("R9", S_RD, 32'h0B);
        expect_val("R9", S_RESUME, 32'h5000);
        wait (sb.size() == 0);
        // R9 error and trap together: error wins, cause untouched
        drive(1, 5'd12, 32'h6000, 1, 1, 0, 0, A_CAUSE, '0);
        read_chk("R9", A_CAUSE, 32'h7);
        read_chk("R9", A_ERRPC, 32'h6000);
        read_chk("R9", A_RETPC, 32'h5000);

        // R10 software cannot touch level bits or cause
        wr_reg(A_STATUS, 32'h0);
        read_chk("R10", A_STATUS, 32'h06);
        wr_reg(A_CAUSE, 32'hFFFF_FFFF);
        read_chk("R10", A_CAUSE, 32'h7);
        wr_reg(A_RETPC, 32'h1234_5678);
        read_chk("R10", A_RETPC, 32'h1234_5678);
        wr_reg(A_ERRPC, 32'hCAFE_0000);
        quiet(A_ERRPC);
        expect_val("R10", S_RESUME, 32'hCAFE_0000);
        expect_val("R7", S_USER, 0);
        wait (sb.size() == 0);
        read_chk("R10", 3'd7, 32'h0);

        done = 1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule